// File: doc/BRIEF.md
# Two-Level Shift-and-Add Constant Multiplier

This block multiplies each incoming fixed-point sample by the fixed integer 2228241. It does not use a general multiplier. The constant factors as (2^4 + 1)(2^17 + 1), so the datapath uses two shift-and-add levels.

- The first level forms a reusable term T = X + (X << 4), which is 17·X.
- The second level forms (T << 17) + T.

In each level, the bits below the shift amount pass straight through without any adder cells. When the shift is at least as wide as the operand and the input is unsigned, the whole level reduces to wiring.

The input is unsigned or two's complement, chosen by a parameter. The product is delivered at full precision, WX + 22 bits. Each level ends in a register, so results arrive at a fixed latency with a valid flag alongside. The data registers load only on valid samples, so the output keeps its last product during bubbles.

Top module: `scm_mult_top`

## Requirements
- R1: With SIGNED = 0, a valid unsigned input X produces out_data = X·2228241 as a WX+22 bit unsigned value.
- R2: With SIGNED = 1, in_data is two's complement and out_data is the exact product X·2228241 in two's complement over the full WX+22 bits.
- R3: out_valid equals the in_valid presented two rising clock edges earlier, and the matching product appears on out_data in that same cycle.
- R4: An in_valid low sample does not change out_data: while out_valid is low, out_data keeps the last product delivered.
- R5: A synchronous active-high rst forces out_valid to 0 and out_data to 0 from the first clock edge at which it is sampled high.
- R6: The extreme inputs are exact: zero, one, all ones, the largest positive value and the most negative value.
- R7: Bits [3:0] of a delivered product equal bits [3:0] of the input that produced it. They travel through both levels without an adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a sample to multiply |
| in_data | input | WX | Multiplicand, unsigned or two's complement per SIGNED |
| out_valid | output | 1 | Marks out_data as a fresh product |
| out_data | output | WX+22 | Full-precision product X·2228241 |

## Verification
A sample driven before rising edge N is captured by the first level at edge N. It reaches the output registers at edge N+1, so its product and valid flag are due on the ports after edge N+1 and stay until edge N+2.

The bench drives inputs on falling edges and keeps a two-entry expected-value pipeline per instance. At every falling edge it compares the ports against the entry pushed two falling edges earlier. A bubble in that entry turns the data check into a check that the previous product is held.

Three instances run side by side:
- an unsigned 10-bit instance, where the second level is pure wiring;
- a signed 10-bit instance;
- a signed 16-bit instance.

Both 10-bit instances see every input value.

// File: rtl/scm_pkg.sv
package scm_pkg;
  // Constant = (2^LO_SHIFT + 1) * (2^HI_SHIFT + 1)
  localparam int LO_SHIFT  = 4;
  localparam int HI_SHIFT  = 17;
  localparam int CONST_W   = 22;
  localparam longint CONST_VAL = ((64'd1 << LO_SHIFT) + 64'd1) * ((64'd1 << HI_SHIFT) + 64'd1);

  function automatic int prod_width(input int wx);
    return wx + CONST_W;
  endfunction

  function automatic int level_width(input int w_in, input int shift);
    return w_in + shift + 1;
  endfunction
endpackage

// File: rtl/scm_upper_sum.sv
// Upper part of a + (a << SHIFT) over the extended operand.
// Unsigned operands no wider than the shift give a pure wiring variant.
module scm_upper_sum #(
  parameter int W_IN   = 8,
  parameter int SHIFT  = 4,
  parameter bit SIGNED = 1'b0
) (
  input  logic [W_IN:0] hi_part,
  input  logic [W_IN:0] base_part,
  output logic [W_IN:0] upper
);
  generate
    if (!SIGNED && (SHIFT >= W_IN)) begin : g_concat
      // hi_part is all zeros here: the level is a concatenation
      logic unused_hi;
      assign unused_hi = &{1'b0, hi_part};
      assign upper = base_part;
    end else begin : g_adder
      assign upper = hi_part + base_part;
    end
  endgenerate
endmodule

// File: rtl/scm_shift_add_stage.sv
// One registered level: y = a * (2^SHIFT + 1), exact width W_IN+SHIFT+1.
module scm_shift_add_stage #(
  parameter int W_IN   = 8,
  parameter int SHIFT  = 4,
  parameter bit SIGNED = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [W_IN-1:0]         in_data,
  output logic                    out_valid,
  output logic [W_IN+SHIFT:0]     out_data
);
  localparam int W_OUT = scm_pkg::level_width(W_IN, SHIFT);
  localparam int W_UP  = W_IN + 1;

  logic [W_OUT-1:0] a_ext;
  logic [W_UP-1:0]  upper;
  logic [W_OUT-1:0] sum;

  generate
    if (SIGNED) begin : g_sext
      assign a_ext = {{(SHIFT+1){in_data[W_IN-1]}}, in_data};
    end else begin : g_zext
      assign a_ext = {{(SHIFT+1){1'b0}}, in_data};
    end
  endgenerate

  scm_upper_sum #(
    .W_IN   (W_IN),
    .SHIFT  (SHIFT),
    .SIGNED (SIGNED)
  ) upper_i (
    .hi_part   (a_ext[W_OUT-1:SHIFT]),
    .base_part (a_ext[W_IN:0]),
    .upper     (upper)
  );

  // low SHIFT bits bypass the adder entirely
  assign sum = {upper, a_ext[SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sum;
    end
  end
endmodule

// File: rtl/scm_mult_top.sv
module scm_mult_top #(
  parameter int WX     = 16,
  parameter bit SIGNED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WX-1:0]        in_data,
  output logic                 out_valid,
  output logic [WX+21:0]       out_data
);
  localparam int WR = scm_pkg::prod_width(WX);
  localparam int W1 = scm_pkg::level_width(WX, scm_pkg::LO_SHIFT);
  localparam int W2 = scm_pkg::level_width(W1, scm_pkg::HI_SHIFT);

  logic          t_valid;
  logic [W1-1:0] t_data;
  logic [W2-1:0] r_data;

  // level 1: T = 17 * X
  scm_shift_add_stage #(
    .W_IN   (WX),
    .SHIFT  (scm_pkg::LO_SHIFT),
    .SIGNED (SIGNED)
  ) lvl1_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (t_valid),
    .out_data  (t_data)
  );

  // level 2: R = (T << 17) + T
  scm_shift_add_stage #(
    .W_IN   (W1),
    .SHIFT  (scm_pkg::HI_SHIFT),
    .SIGNED (SIGNED)
  ) lvl2_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (t_valid),
    .in_data   (t_data),
    .out_valid (out_valid),
    .out_data  (r_data)
  );

  // product fits WR bits; the level-2 top bit is redundant
  logic unused_top;
  assign unused_top = &{1'b0, r_data[W2-1:WR]};
  assign out_data   = r_data[WR-1:0];
endmodule

// File: rtl/scm_mult_chk.sv
module scm_mult_chk #(
  parameter int WX     = 16,
  parameter bit SIGNED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WX-1:0]    in_data,
  input logic             out_valid,
  input logic [WX+21:0]   out_data
);
  localparam int WR = WX + 22;

  logic [1:0]    since_rst;
  logic [WR-1:0] x_ext;
  logic [WR-1:0] ref_prod;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  generate
    if (SIGNED) begin : g_s
      assign x_ext = {{22{in_data[WX-1]}}, in_data};
    end else begin : g_u
      assign x_ext = {22'd0, in_data};
    end
  endgenerate

  assign ref_prod = x_ext * WR'(scm_pkg::CONST_VAL);

  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // covers R1 and R2 per SIGNED
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_valid) |-> (out_data == $past(ref_prod, 2)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !out_valid) |-> $stable(out_data));

  generate
    if (WX >= 4) begin : g_low
      a_r7_low_bypass: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_data[3:0] == $past(in_data[3:0], 2)));
    end
  endgenerate
endmodule

bind scm_mult_top scm_mult_chk #(.WX(WX), .SIGNED(SIGNED)) chk_i (.*);

// File: tb/scm_mult_top_tb_top.sv
module scm_mult_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint KC = 64'd2228241;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // dut_i: signed 16-bit; dut_u: unsigned 10-bit; dut_s: signed 10-bit
  logic        vi_in, vu_in, vs_in;
  logic [15:0] xi_in;
  logic [9:0]  xu_in, xs_in;
  logic        vi_out, vu_out, vs_out;
  logic [37:0] di_out;
  logic [31:0] du_out, ds_out;

  scm_mult_top #(.WX(16), .SIGNED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(vi_in), .in_data(xi_in),
    .out_valid(vi_out), .out_data(di_out));
  scm_mult_top #(.WX(10), .SIGNED(1'b0)) dut_u (
    .clk(clk), .rst(rst), .in_valid(vu_in), .in_data(xu_in),
    .out_valid(vu_out), .out_data(du_out));
  scm_mult_top #(.WX(10), .SIGNED(1'b1)) dut_s (
    .clk(clk), .rst(rst), .in_valid(vs_in), .in_data(xs_in),
    .out_valid(vs_out), .out_data(ds_out));

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // expected-value pipeline, lane 0 = dut_i, 1 = dut_u, 2 = dut_s
  logic        pv   [3][2];
  logic [63:0] pd   [3][2];
  string       ptag [3][2];
  logic [63:0] cur  [3];
  logic [3:0]  plo  [2];

  function automatic logic [63:0] exp_s16(input logic [15:0] x);
    longint v = longint'($signed(x)) * KC;
    return 64'(v) & ((64'd1 << 38) - 1);
  endfunction
  function automatic logic [63:0] exp_u10(input logic [9:0] x);
    return {54'd0, x} * KC;
  endfunction
  function automatic logic [63:0] exp_s10(input logic [9:0] x);
    longint v = longint'($signed(x)) * KC;
    return 64'(v) & ((64'd1 << 32) - 1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_lane(input int k, input logic ov, input logic [63:0] od);
    if (pv[k][1]) cur[k] = pd[k][1];
    chk("R3 valid latency", {63'd0, ov}, {63'd0, pv[k][1]});
    chk(pv[k][1] ? ptag[k][1] : "R4 hold on bubble", od, cur[k]);
  endtask

  task automatic step(input logic vi, input logic [15:0] xi, input string ti,
                      input logic vu, input logic [9:0] xu,
                      input logic vs, input logic [9:0] xs);
    @(negedge clk);
    check_lane(0, vi_out, {26'd0, di_out});
    check_lane(1, vu_out, {32'd0, du_out});
    check_lane(2, vs_out, {32'd0, ds_out});
    if (pv[1][1]) chk("R7 low bits bypass", {60'd0, du_out[3:0]}, {60'd0, plo[1]});
    for (int k = 0; k < 3; k++) begin
      pv[k][1] = pv[k][0]; pd[k][1] = pd[k][0]; ptag[k][1] = ptag[k][0];
    end
    plo[1] = plo[0];
    vi_in = vi; xi_in = xi; vu_in = vu; xu_in = xu; vs_in = vs; xs_in = xs;
    pv[0][0] = vi; pd[0][0] = exp_s16(xi); ptag[0][0] = ti;
    pv[1][0] = vu; pd[1][0] = exp_u10(xu); ptag[1][0] = "R1 unsigned product";
    pv[2][0] = vs; pd[2][0] = exp_s10(xs); ptag[2][0] = "R2 signed product";
    plo[0] = xu[3:0];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] directed [8];
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0017);
    directed = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000,
                 16'h8001, 16'h7FFE, 16'h0010};
    vi_in = 1'b1; xi_in = 16'hFFFF; vu_in = 1'b1; xu_in = '1; vs_in = 1'b1; xs_in = '1;
    for (int k = 0; k < 3; k++) begin
      pv[k][0] = 1'b0; pv[k][1] = 1'b0; pd[k][0] = '0; pd[k][1] = '0;
      ptag[k][0] = ""; ptag[k][1] = ""; cur[k] = '0;
    end
    plo[0] = '0; plo[1] = '0;

    // R5: reset dominates active inputs
    repeat (3) begin
      @(negedge clk);
      chk("R5 reset valid", {61'd0, vi_out, vu_out, vs_out}, 64'd0);
      chk("R5 reset data", {26'd0, di_out} | {32'd0, du_out} | {32'd0, ds_out}, 64'd0);
    end
    rst = 1'b0;
    vi_in = 1'b0; vu_in = 1'b0; vs_in = 1'b0;

    // exhaustive 10-bit sweep, directed extremes on the 16-bit lane, bubbles
    for (int i = 0; i < 1024; i++) begin
      if (i % 9 == 4)
        step(1'b0, 16'($urandom), "", 1'b0, 10'($urandom), 1'b0, 10'($urandom));
      if (i < 8)
        step(1'b1, directed[i], "R6 extreme input", 1'b1, 10'(i), 1'b1, 10'(i));
      else
        step(1'b1, 16'($urandom), "R2 signed product", 1'b1, 10'(i), 1'b1, 10'(i));
    end
    // 10-bit extremes, tagged through their lanes by value
    step(1'b1, 16'h8000, "R6 extreme input", 1'b1, 10'h3FF, 1'b1, 10'h200);
    step(1'b1, 16'h7FFF, "R6 extreme input", 1'b1, 10'h000, 1'b1, 10'h1FF);

    // random valid pattern
    for (int i = 0; i < 2000; i++)
      step(1'($urandom), 16'($urandom), "R2 signed product",
           1'($urandom), 10'($urandom), 1'($urandom), 10'($urandom));

    // drain
    repeat (3) step(1'b0, 16'h1234, "", 1'b0, 10'h155, 1'b0, 10'h2AA);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule